// File: doc/BRIEF.md
# Descriptor and Report Ring Pair

This block gives one channel of a cyclic DMA engine its two four-slot queues. Software describes a transfer with four 32-bit words written one after another to a single push port. Once the fourth word arrives the descriptor enters the descriptor ring. The transfer engine takes the oldest descriptor. From then on it reports the bytes it moves as beats, and the block counts a residue register down from the descriptor's length.

When a descriptor that asks for notification runs out, the block places a four-word report in the report ring and raises a one-cycle done event. Software reads the report back as four word reads from a single pop port.

Each ring has a status word. It carries the write and read slot indices, separate full and empty bits to tell apart the two cases where the indices are equal, and a sticky error bit. A channel control bit holds both rings, the partial descriptor, the active transfer and the byte total in their reset state until software clears it again.

Top module: `desc_report_rings`

## Requirements
- R1: Each ring holds at most 4 entries. The full bit is set at 4 occupied slots and the empty bit at 0. Otherwise occupancy is (write slot - read slot + 4) mod 4.
- R2: Ring status word layout: write slot in bits [1:0], read slot in bits [5:4], empty in bit 8, full in bit 9, error in bit 10. All other bits read 0. After reset both status words read 0x100.
- R3: Descriptor words arrive in this order: address low, address high, length in bytes, flags. The descriptor enters the ring only on its fourth word. The head outputs show the oldest descriptor's 64-bit address and its length.
- R4: If a fourth descriptor word arrives while the descriptor ring is full, the descriptor is discarded and the descriptor ring's error bit is set.
- R5: A pulse on a ring's error-clear input clears that ring's error bit. This matches writing 1 to bit 10 of the status word.
- R6: While the ring-reset control bit is 1, both rings are empty with zero slots, the partial word count is zero, both error bits are clear, no transfer is active, the residue is 0 and the running byte total is 0.
- R7: Taking a descriptor loads the residue with its length. Each beat lowers the residue by the beat's byte count, and the residue stops at 0. A take is accepted only when the descriptor ring is not empty and no transfer is active.
- R8: When the residue of a descriptor with flag bit 16 set reaches 0, a report is pushed and desc_done is high for exactly one cycle. The report holds, in order: the running byte total low word, its high word, the descriptor length, and the descriptor flags.
- R9: A descriptor without flag bit 16 finishes without pushing a report and without a done event.
- R10: The report pop port returns the head report's four words in order. The report leaves the ring after its fourth word is read.
- R11: A read from an empty report ring returns 0 and sets the report ring's error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the channel control bit |
| ctl_ring_rst | input | 1 | Ring-reset value written on ctl_wr_en |
| dring_err_clr | input | 1 | Clears the descriptor ring error bit |
| rring_err_clr | input | 1 | Clears the report ring error bit |
| desc_push_en | input | 1 | One descriptor word is present this cycle |
| desc_push_word | input | 32 | Descriptor word |
| rpt_pop_en | input | 1 | One report word is read this cycle |
| rpt_pop_word | output | 32 | Report word returned for this read (combinational) |
| dring_status | output | 32 | Descriptor ring status word |
| rring_status | output | 32 | Report ring status word |
| head_avail | output | 1 | A descriptor can be taken |
| head_addr | output | 64 | Address of the oldest descriptor |
| head_len | output | 32 | Length of the oldest descriptor |
| xfer_take | input | 1 | Engine takes the oldest descriptor |
| xfer_beat | input | 1 | Engine moved bytes this cycle |
| xfer_beat_bytes | input | 16 | Bytes moved in this beat |
| residue | output | 32 | Bytes left in the active descriptor |
| desc_done | output | 1 | One-cycle event for a finished notifying descriptor |

## Verification
On every cycle the assertions check four things. The occupancy never exceeds four. Full and empty are never both set, and equal slot indices always come with one of them. The residue rises only after an accepted take, and a done event never lasts more than one cycle and always leaves a report in the ring. Other properties cannot be seen cycle by cycle and are covered by the bench's scenarios: word order, commit on the fourth word, discard of an overflowing descriptor, the report contents and the byte total, the zero returned on an empty read, and ring reset clearing a half-written descriptor.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W     = 32;
  localparam int SLOTS      = 4;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int ENTRY_W    = 4 * WORD_W;
  localparam int NOTIFY_BIT = 16;
  localparam int ST_WR_LSB  = 0;
  localparam int ST_RD_LSB  = 4;
  localparam int ST_EMPTY   = 8;
  localparam int ST_FULL    = 9;
  localparam int ST_ERR     = 10;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic [SLOT_W-1:0] wr, input logic [SLOT_W-1:0] rd,
    input logic empty, input logic full, input logic err);
    logic [WORD_W-1:0] s;
    s = '0;
    s[ST_WR_LSB +: SLOT_W] = wr;
    s[ST_RD_LSB +: SLOT_W] = rd;
    s[ST_EMPTY] = empty;
    s[ST_FULL]  = full;
    s[ST_ERR]   = err;
    return s;
  endfunction
endpackage

// File: rtl/slot_ring.sv
module slot_ring #(
  parameter int ENTRY_W = 128,
  parameter int DEPTH   = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head_data,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic [PTR_W-1:0]   rd_ptr,
  output logic               full,
  output logic               empty
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [PTR_W-1:0]   wr_n, rd_n;
  logic               do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head_data = mem[rd_ptr];

  always_comb begin
    wr_n  = wr_ptr;
    rd_n  = rd_ptr;
    cnt_n = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = wr_ptr + 1'b1;
      if (do_pop)  rd_n = rd_ptr + 1'b1;
      cnt_n = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_n;
      rd_ptr <= rd_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // R1: occupancy bound
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R1: full and empty exclusive, equal pointers imply one of them
  a_r1_ptr_equal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty) && ((wr_ptr == rd_ptr) == (full || empty)));
  // R4: a push into a full ring leaves it full
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> full);
endmodule

// File: rtl/residue_track.sv
module residue_track #(
  parameter int LEN_W  = 32,
  parameter int BEAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              beat,
  input  logic [BEAT_W-1:0] beat_bytes,
  output logic [LEN_W-1:0]  residue,
  output logic              active,
  output logic              finish,
  output logic [LEN_W-1:0]  consumed
);
  logic [LEN_W-1:0] beat_ext, res_n;
  logic             act_n;

  assign beat_ext = LEN_W'(beat_bytes);
  assign finish   = active && beat && (beat_ext >= residue);

  always_comb begin
    consumed = '0;
    if (active && beat) consumed = finish ? residue : beat_ext;
  end

  always_comb begin
    res_n = residue;
    act_n = active;
    if (clr) begin
      res_n = '0;
      act_n = 1'b0;
    end else if (load && !active) begin
      res_n = load_len;
      act_n = 1'b1;
    end else if (active && beat) begin
      res_n = residue - consumed;
      if (finish) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      residue <= '0;
      active  <= 1'b0;
    end else begin
      residue <= res_n;
      active  <= act_n;
    end
  end

  // R7: residue only rises after an accepted load
  a_r7_rise_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (residue > $past(residue)) |-> $past(load && !active && !clr));
endmodule

// File: rtl/desc_report_rings.sv
module desc_report_rings
  import dring_pkg::*;
#(
  parameter int BEAT_W = 16,
  parameter int TOT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic              ctl_ring_rst,
  input  logic              dring_err_clr,
  input  logic              rring_err_clr,
  input  logic              desc_push_en,
  input  logic [31:0]       desc_push_word,
  input  logic              rpt_pop_en,
  output logic [31:0]       rpt_pop_word,
  output logic [31:0]       dring_status,
  output logic [31:0]       rring_status,
  output logic              head_avail,
  output logic [63:0]       head_addr,
  output logic [31:0]       head_len,
  input  logic              xfer_take,
  input  logic              xfer_beat,
  input  logic [BEAT_W-1:0] xfer_beat_bytes,
  output logic [31:0]       residue,
  output logic              desc_done
);
  logic               rst_hold_q;
  logic [1:0]         wcnt_q, wcnt_n, ridx_q, ridx_n;
  logic [WORD_W-1:0]  sh0_q, sh1_q, sh2_q;
  logic               derr_q, derr_n, rerr_q, rerr_n, done_n;
  logic [WORD_W-1:0]  act_flags_q, act_len_q;
  logic [TOT_W-1:0]   tot_q, tot_n;
  logic [ENTRY_W-1:0] d_head, r_head, d_entry, r_entry;
  logic [SLOT_W-1:0]  d_wr, d_rd, r_wr, r_rd;
  logic               d_full, d_empty, r_full, r_empty;
  logic               commit, d_push, take_ok, r_push, r_pop;
  logic               active, finish;
  logic [WORD_W-1:0]  consumed;

  assign commit  = desc_push_en && (wcnt_q == 2'd3) && !rst_hold_q;
  assign d_push  = commit && !d_full;
  assign d_entry = {desc_push_word, sh2_q, sh1_q, sh0_q};
  assign head_avail = !d_empty && !active && !rst_hold_q;
  assign take_ok = xfer_take && head_avail;
  assign head_addr = d_head[63:0];
  assign head_len  = d_head[95:64];
  assign tot_n   = tot_q + TOT_W'(consumed);
  assign r_push  = finish && act_flags_q[NOTIFY_BIT];
  assign r_entry = {act_flags_q, act_len_q, tot_n[63:32], tot_n[31:0]};
  assign r_pop   = rpt_pop_en && !r_empty && (ridx_q == 2'd3) && !rst_hold_q;
  assign rpt_pop_word = r_empty ? '0 : r_head[ridx_q*WORD_W +: WORD_W];
  assign dring_status = pack_status(d_wr, d_rd, d_empty, d_full, derr_q);
  assign rring_status = pack_status(r_wr, r_rd, r_empty, r_full, rerr_q);

  slot_ring #(.ENTRY_W(ENTRY_W), .DEPTH(SLOTS)) i_dring (
    .clk(clk), .rst_n(rst_n), .clr(rst_hold_q), .push(d_push),
    .push_data(d_entry), .pop(take_ok), .head_data(d_head),
    .wr_ptr(d_wr), .rd_ptr(d_rd), .full(d_full), .empty(d_empty));

  slot_ring #(.ENTRY_W(ENTRY_W), .DEPTH(SLOTS)) i_rring (
    .clk(clk), .rst_n(rst_n), .clr(rst_hold_q), .push(r_push),
    .push_data(r_entry), .pop(r_pop), .head_data(r_head),
    .wr_ptr(r_wr), .rd_ptr(r_rd), .full(r_full), .empty(r_empty));

  residue_track #(.LEN_W(WORD_W), .BEAT_W(BEAT_W)) i_residue (
    .clk(clk), .rst_n(rst_n), .clr(rst_hold_q), .load(take_ok),
    .load_len(head_len), .beat(xfer_beat), .beat_bytes(xfer_beat_bytes),
    .residue(residue), .active(active), .finish(finish), .consumed(consumed));

  always_comb begin
    wcnt_n = wcnt_q;
    ridx_n = ridx_q;
    derr_n = derr_q;
    rerr_n = rerr_q;
    if (rst_hold_q) begin
      wcnt_n = '0;
      ridx_n = '0;
      derr_n = 1'b0;
      rerr_n = 1'b0;
    end else begin
      if (desc_push_en) wcnt_n = wcnt_q + 1'b1;
      if (rpt_pop_en && !r_empty) ridx_n = ridx_q + 1'b1;
      if (dring_err_clr) derr_n = 1'b0;
      if (commit && d_full) derr_n = 1'b1;
      if (rring_err_clr) rerr_n = 1'b0;
      if ((rpt_pop_en && r_empty) || (r_push && r_full)) rerr_n = 1'b1;
    end
    done_n = r_push && !rst_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_hold_q <= 1'b0;
      wcnt_q     <= '0;
      ridx_q     <= '0;
      derr_q     <= 1'b0;
      rerr_q     <= 1'b0;
      desc_done  <= 1'b0;
      tot_q      <= '0;
    end else begin
      if (ctl_wr_en) rst_hold_q <= ctl_ring_rst;
      wcnt_q    <= wcnt_n;
      ridx_q    <= ridx_n;
      derr_q    <= derr_n;
      rerr_q    <= rerr_n;
      desc_done <= done_n;
      if (rst_hold_q) tot_q <= '0;
      else if (active && xfer_beat) tot_q <= tot_n;
    end
  end

  always_ff @(posedge clk) begin
    if (desc_push_en && wcnt_q == 2'd0) sh0_q <= desc_push_word;
    if (desc_push_en && wcnt_q == 2'd1) sh1_q <= desc_push_word;
    if (desc_push_en && wcnt_q == 2'd2) sh2_q <= desc_push_word;
    if (take_ok) begin
      act_len_q   <= head_len;
      act_flags_q <= d_head[127:96];
    end
  end

  // R8: done event lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);
  // R8: a done event leaves a report in the ring
  a_r8_done_has_report: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> !r_empty);
  // R4: overflowing commit raises the descriptor error
  a_r4_overflow_err: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && d_full) |=> derr_q);
  // R6: ring reset empties both rings
  a_r6_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_hold_q) && rst_hold_q |-> (d_empty && r_empty && !active));
endmodule

// File: tb/test_desc_report_rings.sv
module test_desc_report_rings;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr_en, ctl_ring_rst, dring_err_clr, rring_err_clr;
  logic desc_push_en, rpt_pop_en, xfer_take, xfer_beat;
  logic [31:0] desc_push_word, rpt_pop_word, dring_status, rring_status;
  logic [31:0] head_len, residue;
  logic [63:0] head_addr;
  logic [15:0] xfer_beat_bytes;
  logic head_avail, desc_done;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  desc_report_rings i_desc_report_rings (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_ring_rst(ctl_ring_rst),
    .dring_err_clr(dring_err_clr), .rring_err_clr(rring_err_clr),
    .desc_push_en(desc_push_en), .desc_push_word(desc_push_word),
    .rpt_pop_en(rpt_pop_en), .rpt_pop_word(rpt_pop_word),
    .dring_status(dring_status), .rring_status(rring_status),
    .head_avail(head_avail), .head_addr(head_addr), .head_len(head_len),
    .xfer_take(xfer_take), .xfer_beat(xfer_beat), .xfer_beat_bytes(xfer_beat_bytes),
    .residue(residue), .desc_done(desc_done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_wr_en = 0; ctl_ring_rst = 0; dring_err_clr = 0; rring_err_clr = 0;
    desc_push_en = 0; desc_push_word = '0; rpt_pop_en = 0;
    xfer_take = 0; xfer_beat = 0; xfer_beat_bytes = '0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); desc_push_en = 1; desc_push_word = w;
    @(negedge clk); desc_push_en = 0;
  endtask

  task automatic push_desc(input logic [63:0] a, input logic [31:0] len, input logic [31:0] fl);
    push_word(a[31:0]); push_word(a[63:32]); push_word(len); push_word(fl);
  endtask

  task automatic pop_word(output logic [31:0] w);
    @(negedge clk); rpt_pop_en = 1; #1 w = rpt_pop_word;
    @(negedge clk); rpt_pop_en = 0;
  endtask

  task automatic take();
    @(negedge clk); xfer_take = 1;
    @(negedge clk); xfer_take = 0;
  endtask

  task automatic beat(input logic [15:0] n);
    @(negedge clk); xfer_beat = 1; xfer_beat_bytes = n;
    @(negedge clk); xfer_beat = 0;
  endtask

  task automatic ring_reset();
    @(negedge clk); ctl_wr_en = 1; ctl_ring_rst = 1;
    @(negedge clk); ctl_ring_rst = 0;
    @(negedge clk); ctl_wr_en = 0;
  endtask

  task automatic t_reset_state();
    chk("R2 dring reset", dring_status, 32'h100);
    chk("R2 rring reset", rring_status, 32'h100);
    chk("R7 residue reset", residue, 0);
    chk("R8 done reset", desc_done, 0);
    chk("R7 head_avail reset", head_avail, 0);
  endtask

  task automatic t_commit_on_fourth();
    push_word(32'hA000_0000); push_word(32'h0000_0001); push_word(32'h40);
    chk("R3 no commit after 3 words", dring_status, 32'h100);
    push_word(32'h0001_0000);
    chk("R1 R2 one entry", dring_status, 32'h001);
    chk("R3 head addr", head_addr, 64'h1_A000_0000);
    chk("R3 head len", head_len, 32'h40);
    chk("R7 head avail", head_avail, 1);
  endtask

  task automatic t_fill_overflow();
    push_desc(64'hB000, 32'h20, 32'h0);
    push_desc(64'hC000, 32'h08, 32'h1_0000);
    push_desc(64'hD000, 32'h100, 32'h0);
    chk("R1 full", dring_status, 32'h200);
    push_desc(64'hE000, 32'h55, 32'h0);
    chk("R4 overflow error", dring_status, 32'h600);
    chk("R4 head unchanged", head_addr, 64'h1_A000_0000);
    @(negedge clk); dring_err_clr = 1;
    @(negedge clk); dring_err_clr = 0;
    chk("R5 error cleared", dring_status, 32'h200);
  endtask

  task automatic t_notify_finish();
    logic [31:0] w;
    take();
    chk("R7 residue loaded", residue, 32'h40);
    chk("R1 R2 slots after take", dring_status, 32'h010);
    chk("R7 no take while active", head_avail, 0);
    beat(16'h10);
    chk("R7 residue down", residue, 32'h30);
    @(negedge clk); xfer_beat = 1; xfer_beat_bytes = 16'h50;
    @(negedge clk); xfer_beat = 0;
    chk("R8 done pulse", desc_done, 1);
    chk("R7 residue floor", residue, 0);
    chk("R8 report pushed", rring_status, 32'h001);
    @(negedge clk);
    chk("R8 done one cycle", desc_done, 0);
    pop_word(w); chk("R10 count lo", w, 32'h40);
    pop_word(w); chk("R10 count hi", w, 0);
    pop_word(w); chk("R10 aux len", w, 32'h40);
    pop_word(w); chk("R10 flags", w, 32'h1_0000);
    chk("R10 report popped", rring_status, 32'h111);
  endtask

  task automatic t_empty_read();
    logic [31:0] w;
    pop_word(w);
    chk("R11 empty read zero", w, 0);
    chk("R11 error set", rring_status, 32'h511);
    @(negedge clk); rring_err_clr = 1;
    @(negedge clk); rring_err_clr = 0;
    chk("R5 report error cleared", rring_status, 32'h111);
  endtask

  task automatic t_silent_finish();
    logic [31:0] w;
    take();
    chk("R7 residue reload", residue, 32'h20);
    beat(16'h20);
    chk("R9 no done", desc_done, 0);
    chk("R9 no report", rring_status, 32'h111);
    take();
    chk("R7 residue reload again", residue, 32'h08);
    beat(16'h08);
    chk("R8 done second", desc_done, 1);
    pop_word(w); chk("R8 running total", w, 32'h68);
    pop_word(w); pop_word(w); chk("R8 aux len", w, 32'h08);
    pop_word(w);
    chk("R10 slots", rring_status, 32'h122);
  endtask

  task automatic t_ring_reset();
    logic [31:0] w;
    take();
    beat(16'h10);
    chk("R7 residue partial", residue, 32'hF0);
    push_word(32'hDEAD); push_word(32'hBEEF);
    ring_reset();
    chk("R6 dring cleared", dring_status, 32'h100);
    chk("R6 rring cleared", rring_status, 32'h100);
    chk("R6 residue cleared", residue, 0);
    push_desc(64'h2_0000_F000, 32'h18, 32'h1_0000);
    chk("R6 partial dropped addr", head_addr, 64'h2_0000_F000);
    chk("R6 partial dropped len", head_len, 32'h18);
    take(); beat(16'h18);
    pop_word(w);
    chk("R6 total restarted", w, 32'h18);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_commit_on_fourth();
    t_fill_overflow();
    t_notify_finish();
    t_empty_read();
    t_silent_finish();
    t_ring_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule